// File: doc/BRIEF.md
# DMA Channel with Graceful Halt and Abrupt Disable

This block is one DMA channel. It copies 32-bit words from a source port to a destination port through a small internal FIFO. Software first loads a descriptor: source and destination base addresses, the follow-on descriptor pointer, a word count and two address-increment bits. It then writes the configuration register, and setting the enable bit in that write starts the channel. A peripheral request line paces the source side. Each request that the channel accepts allows exactly one source read. The destination side writes out whatever the FIFO holds.

There are two ways to stop the channel. The first is a halt. It stops new requests from being accepted but lets buffered data drain. Software polls the active output until it reads 0 and can then disable the channel without losing data. The second is to clear the enable bit. The bus beat that completes in that cycle still takes effect, and then the FIFO and the remaining count are thrown away. When the last word is written, the channel clears its own enable bit. Terminal-count and error flags stay set until software clears them with separate pulse inputs. Only single-block transfers run: a non-zero follow-on pointer is refused.

Top module: `dma_halt_drain`

## Requirements
- R1: After reset, ch_enable, ch_active, src_valid, dst_valid, irq_tc and irq_err are all 0.
- R2: A cfg_we pulse with cfg_enable=1 while the channel is disabled, with a zero follow-on pointer and a non-zero remaining count, sets ch_enable on the next cycle. A prog_we pulse while ch_enable=1 is ignored.
- R3: A peripheral request is accepted only while the channel is enabled, not halted, has no accepted request outstanding and has source words left. Each accepted request produces exactly one source read, and src_valid is raised only while the 4-word FIFO has a free slot.
- R4: dst_valid is 1 whenever the channel is enabled and the FIFO is non-empty. dst_data presents the words in the order the source delivered them.
- R5: After each completed beat, with no error, src_addr (dst_addr) grows by 4 when its increment bit was set in the descriptor, and stays the same otherwise.
- R6: While the halt bit is set, no new request is accepted, but a request accepted earlier is still read and written out. Once halt is cleared, requests are accepted again.
- R7: ch_active is 1 exactly when the channel is enabled and either the FIFO holds data or an accepted request is still outstanding.
- R8: A cfg_we pulse with cfg_enable=0 while the channel is enabled clears ch_enable on the next cycle. It also empties the FIFO, drops any outstanding request and zeroes the remaining count, so a later enable with no new descriptor completes at once.
- R9: The destination beat that writes the last word clears ch_enable and sets irq_tc on the next cycle.
- R10: Enabling with a remaining count of zero sets irq_tc on the next cycle, leaves ch_enable at 0 and raises no bus valid.
- R11: Enabling with a non-zero follow-on pointer sets irq_err and leaves ch_enable at 0.
- R12: A completed handshake with src_err or dst_err set raises irq_err, clears ch_enable and empties the FIFO, all on the next cycle.
- R13: irq_tc and irq_err stay set across reprogramming until clr_tc or clr_err is pulsed. If a flag is set and cleared in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prog_we | input | 1 | Load the descriptor (ignored while enabled) |
| prog_src | input | 32 | Source base address |
| prog_dst | input | 32 | Destination base address |
| prog_next | input | 32 | Follow-on descriptor pointer; only zero runs |
| prog_count | input | 12 | Word count |
| prog_src_inc | input | 1 | Source address increments by 4 per word |
| prog_dst_inc | input | 1 | Destination address increments by 4 per word |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Enable bit written by cfg_we |
| cfg_halt | input | 1 | Halt bit written by cfg_we |
| clr_tc | input | 1 | Clear pulse for irq_tc |
| clr_err | input | 1 | Clear pulse for irq_err |
| periph_req | input | 1 | Peripheral source request |
| src_valid | output | 1 | Source read request |
| src_addr | output | 32 | Source read address |
| src_ready | input | 1 | Source read completes this cycle |
| src_data | input | 32 | Source read data |
| src_err | input | 1 | Source error response |
| dst_valid | output | 1 | Destination write request |
| dst_addr | output | 32 | Destination write address |
| dst_data | output | 32 | Destination write data |
| dst_ready | input | 1 | Destination write completes this cycle |
| dst_err | input | 1 | Destination error response |
| ch_enable | output | 1 | Channel enable state |
| ch_active | output | 1 | Data still held in the channel |
| irq_tc | output | 1 | Terminal-count flag |
| irq_err | output | 1 | Error flag |

## Verification
The hardest state to reach is a halt that lands while the FIFO is full and a request is already accepted but not yet read. The drain then has to cover both the buffered words and that one pending read. To get there, the bench holds the destination not-ready with requests asserted until all four slots fill and a fifth request is latched. It then sets halt, releases the destination, and checks that exactly five words come out before ch_active falls while requests are still asserted. A behavioural model built on a queue follows every cycle, including runs with randomized ready and request patterns and error injection in the middle of a transfer.

// File: rtl/dma_hd_pkg.sv
package dma_hd_pkg;
  localparam int unsigned WORD_BYTES = 4;

  // Sticky flag update: a set in the same cycle beats a clear.
  function automatic logic flag_next(input logic cur, input logic clr, input logic set);
    return set | (cur & ~clr);
  endfunction
endpackage

// File: rtl/dma_hd_fifo.sv
module dma_hd_fifo #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic [DW-1:0] pop_data,
  output logic          full,
  output logic          empty
);
  localparam int unsigned PTRW = (DEPTH > 2) ? $clog2(DEPTH) : 1;
  localparam int unsigned CNTW = $clog2(DEPTH + 1);

  logic [DW-1:0]   mem [DEPTH];
  logic [PTRW-1:0] wr_ptr, wr_ptr_d, rd_ptr, rd_ptr_d;
  logic [CNTW-1:0] count, count_d;
  logic            ptr_en;

  always_comb begin
    wr_ptr_d = wr_ptr;
    rd_ptr_d = rd_ptr;
    count_d  = count;
    if (flush) begin
      wr_ptr_d = '0;
      rd_ptr_d = '0;
      count_d  = '0;
    end else begin
      if (push) wr_ptr_d = (wr_ptr == PTRW'(DEPTH - 1)) ? '0 : wr_ptr + PTRW'(1);
      if (pop)  rd_ptr_d = (rd_ptr == PTRW'(DEPTH - 1)) ? '0 : rd_ptr + PTRW'(1);
      if (push && !pop)      count_d = count + CNTW'(1);
      else if (pop && !push) count_d = count - CNTW'(1);
    end
  end

  assign ptr_en = flush | push | pop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else if (ptr_en) begin
      wr_ptr <= wr_ptr_d;
      rd_ptr <= rd_ptr_d;
      count  <= count_d;
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    logic slot_we;
    assign slot_we = push && !flush && (wr_ptr == PTRW'(gi));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       mem[gi] <= '0;
      else if (slot_we) mem[gi] <= push_data;
    end
  end

  assign pop_data = mem[rd_ptr];
  assign full     = (count == CNTW'(DEPTH));
  assign empty    = (count == '0);

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (push && !pop && !flush) |-> (count != CNTW'(DEPTH)));
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (count != '0));
  p_flush_empties_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> empty);
endmodule

// File: rtl/dma_hd_cnt.sv
module dma_hd_cnt #(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  input  logic          dec,
  output logic [CW-1:0] cnt,
  output logic          is_zero,
  output logic          is_one
);
  logic [CW-1:0] cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_d = cnt;
    if (clr)       cnt_d = '0;
    else if (load) cnt_d = load_val;
    else if (dec)  cnt_d = cnt - CW'(1);
  end

  assign cnt_en = clr | load | dec;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt <= '0;
    else if (cnt_en) cnt <= cnt_d;
  end

  assign is_zero = (cnt == '0);
  assign is_one  = (cnt == CW'(1));

  p_no_wrap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec |-> !is_zero);
endmodule

// File: rtl/dma_hd_addr.sv
module dma_hd_addr #(
  parameter int unsigned AW   = 32,
  parameter int unsigned STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          step,
  output logic [AW-1:0] addr
);
  logic [AW-1:0] addr_d;
  logic          addr_en;

  always_comb begin
    addr_d = addr;
    if (load)      addr_d = load_val;
    else if (step) addr_d = addr + AW'(STEP);
  end

  assign addr_en = load | step;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       addr <= '0;
    else if (addr_en) addr <= addr_d;
  end

  p_addr_step_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (addr == $past(addr) + AW'(STEP)));
endmodule

// File: rtl/dma_halt_drain.sv
module dma_halt_drain #(
  parameter int unsigned DEPTH = 4,
  parameter int unsigned DW    = 32,
  parameter int unsigned AW    = 32,
  parameter int unsigned CW    = 12,
  parameter int unsigned STEP  = dma_hd_pkg::WORD_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          prog_we,
  input  logic [AW-1:0] prog_src,
  input  logic [AW-1:0] prog_dst,
  input  logic [AW-1:0] prog_next,
  input  logic [CW-1:0] prog_count,
  input  logic          prog_src_inc,
  input  logic          prog_dst_inc,
  input  logic          cfg_we,
  input  logic          cfg_enable,
  input  logic          cfg_halt,
  input  logic          clr_tc,
  input  logic          clr_err,
  input  logic          periph_req,
  output logic          src_valid,
  output logic [AW-1:0] src_addr,
  input  logic          src_ready,
  input  logic [DW-1:0] src_data,
  input  logic          src_err,
  output logic          dst_valid,
  output logic [AW-1:0] dst_addr,
  output logic [DW-1:0] dst_data,
  input  logic          dst_ready,
  input  logic          dst_err,
  output logic          ch_enable,
  output logic          ch_active,
  output logic          irq_tc,
  output logic          irq_err
);
  import dma_hd_pkg::*;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // channel state
  logic en_q, halt_q, pend_q, chain_q, sinc_q, dinc_q, tc_q, err_q;
  logic en_d, halt_d, pend_d, chain_d, sinc_d, dinc_d, tc_d, err_d;

  logic fifo_full, fifo_empty;
  logic rd_zero, rd_one, wr_zero, wr_one;
  logic [CW-1:0] rd_left, wr_left;

  logic hs_src, hs_dst, good_src, good_dst, bus_bad;
  logic start, start_chain, start_zero, start_run, stop_sw, last_beat;
  logic kill, cnt_clr, accept, prog_ld;

  always_comb begin
    hs_src      = src_valid & src_ready;
    hs_dst      = dst_valid & dst_ready;
    good_src    = hs_src & ~src_err;
    good_dst    = hs_dst & ~dst_err;
    bus_bad     = (hs_src & src_err) | (hs_dst & dst_err);
    start       = cfg_we & cfg_enable & ~en_q;
    start_chain = start & chain_q;
    start_zero  = start & ~chain_q & wr_zero;
    start_run   = start & ~chain_q & ~wr_zero;
    stop_sw     = cfg_we & ~cfg_enable & en_q;
    last_beat   = good_dst & wr_one;
    kill        = bus_bad | stop_sw | last_beat;
    cnt_clr     = bus_bad | stop_sw;
    accept      = en_q & ~halt_q & periph_req & ~pend_q & ~rd_zero;
    prog_ld     = prog_we & ~en_q;

    en_d    = kill ? 1'b0 : (start_run ? 1'b1 : en_q);
    halt_d  = cfg_we ? cfg_halt : halt_q;
    if (kill || good_src) pend_d = 1'b0;
    else if (accept)      pend_d = 1'b1;
    else                  pend_d = pend_q;
    chain_d = prog_ld ? (prog_next != '0) : chain_q;
    sinc_d  = prog_ld ? prog_src_inc : sinc_q;
    dinc_d  = prog_ld ? prog_dst_inc : dinc_q;
    tc_d    = flag_next(tc_q,  clr_tc,  last_beat | start_zero);
    err_d   = flag_next(err_q, clr_err, bus_bad | start_chain);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q    <= 1'b0;
      halt_q  <= 1'b0;
      pend_q  <= 1'b0;
      chain_q <= 1'b0;
      sinc_q  <= 1'b0;
      dinc_q  <= 1'b0;
      tc_q    <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      en_q    <= en_d;
      halt_q  <= halt_d;
      pend_q  <= pend_d;
      chain_q <= chain_d;
      sinc_q  <= sinc_d;
      dinc_q  <= dinc_d;
      tc_q    <= tc_d;
      err_q   <= err_d;
    end
  end

  dma_hd_fifo #(.DEPTH(DEPTH), .DW(DW)) u_fifo (
    .clk(clk), .rst_n(rst_sync_n), .flush(kill),
    .push(good_src), .push_data(src_data),
    .pop(good_dst), .pop_data(dst_data),
    .full(fifo_full), .empty(fifo_empty)
  );

  dma_hd_cnt #(.CW(CW)) u_rd_cnt (
    .clk(clk), .rst_n(rst_sync_n), .clr(cnt_clr), .load(prog_ld),
    .load_val(prog_count), .dec(good_src),
    .cnt(rd_left), .is_zero(rd_zero), .is_one(rd_one)
  );

  dma_hd_cnt #(.CW(CW)) u_wr_cnt (
    .clk(clk), .rst_n(rst_sync_n), .clr(cnt_clr), .load(prog_ld),
    .load_val(prog_count), .dec(good_dst),
    .cnt(wr_left), .is_zero(wr_zero), .is_one(wr_one)
  );

  dma_hd_addr #(.AW(AW), .STEP(STEP)) u_src_addr (
    .clk(clk), .rst_n(rst_sync_n), .load(prog_ld), .load_val(prog_src),
    .step(good_src & sinc_q), .addr(src_addr)
  );

  dma_hd_addr #(.AW(AW), .STEP(STEP)) u_dst_addr (
    .clk(clk), .rst_n(rst_sync_n), .load(prog_ld), .load_val(prog_dst),
    .step(good_dst & dinc_q), .addr(dst_addr)
  );

  assign src_valid = en_q & pend_q & ~fifo_full;
  assign dst_valid = en_q & ~fifo_empty;
  assign ch_active = en_q & (pend_q | ~fifo_empty);
  assign ch_enable = en_q;
  assign irq_tc    = tc_q;
  assign irq_err   = err_q;

  p_reads_bounded_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    src_valid |-> !rd_zero);
  p_start_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && cfg_enable && !ch_enable && !chain_q && !wr_zero) |=> ch_enable);
  p_halt_blocks_r6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (halt_q && !pend_q) |=> !pend_q);
  p_disable_drop_r8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && !cfg_enable && ch_enable) |=> (!ch_enable && !ch_active && !dst_valid));
  p_tc_selfclear_r9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (dst_valid && dst_ready && !dst_err && wr_one) |=> (!ch_enable && irq_tc));
  p_zero_count_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && cfg_enable && !ch_enable && !chain_q && wr_zero) |=> (irq_tc && !ch_enable));
  p_chain_refused_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cfg_we && cfg_enable && !ch_enable && chain_q) |=> (irq_err && !ch_enable));
  p_bus_error_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ((src_valid && src_ready && src_err) || (dst_valid && dst_ready && dst_err))
      |=> (irq_err && !ch_enable && !ch_active));
  p_tc_sticky_r13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_tc && !clr_tc) |=> irq_tc);
  p_err_sticky_r13: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (irq_err && !clr_err) |=> irq_err);
endmodule

// File: tb/test_dma_halt_drain.sv
module test_dma_halt_drain;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        prog_we = 1'b0;
  logic [31:0] prog_src = '0, prog_dst = '0, prog_next = '0;
  logic [11:0] prog_count = '0;
  logic        prog_src_inc = 1'b0, prog_dst_inc = 1'b0;
  logic        cfg_we = 1'b0, cfg_enable = 1'b0, cfg_halt = 1'b0;
  logic        clr_tc = 1'b0, clr_err = 1'b0;
  logic        periph_req = 1'b0;
  logic        src_valid, dst_valid;
  logic [31:0] src_addr, dst_addr, dst_data;
  logic        src_ready = 1'b0, dst_ready = 1'b0;
  logic [31:0] src_data = '0;
  logic        src_err = 1'b0, dst_err = 1'b0;
  logic        ch_enable, ch_active, irq_tc, irq_err;

  int n_chk = 0;
  int n_err = 0;
  int cyc = 0;
  int beats = 0;
  int rdy_mode = 0;     // 0: both ready, 1: destination stalled, 2: random
  bit req_rand = 0;
  bit req_want = 0;
  bit inj_src = 0, inj_dst = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  dma_halt_drain i_dma_halt_drain (
    .clk(clk), .rst_n(rst_n),
    .prog_we(prog_we), .prog_src(prog_src), .prog_dst(prog_dst), .prog_next(prog_next),
    .prog_count(prog_count), .prog_src_inc(prog_src_inc), .prog_dst_inc(prog_dst_inc),
    .cfg_we(cfg_we), .cfg_enable(cfg_enable), .cfg_halt(cfg_halt),
    .clr_tc(clr_tc), .clr_err(clr_err), .periph_req(periph_req),
    .src_valid(src_valid), .src_addr(src_addr), .src_ready(src_ready),
    .src_data(src_data), .src_err(src_err),
    .dst_valid(dst_valid), .dst_addr(dst_addr), .dst_data(dst_data),
    .dst_ready(dst_ready), .dst_err(dst_err),
    .ch_enable(ch_enable), .ch_active(ch_active), .irq_tc(irq_tc), .irq_err(irq_err)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  bit          m_en, m_halt, m_pend, m_chain, m_sinc, m_dinc, m_tc, m_err;
  int          m_rdl, m_wrl;
  logic [31:0] m_sa, m_da;
  logic [31:0] q[$];

  always @(posedge clk) begin : mdl
    bit sv, dv, gs, gd, bad, last, start, stop, accept, kill, pl;
    if (!rst_n) begin
      m_en = 0; m_halt = 0; m_pend = 0; m_chain = 0; m_sinc = 0; m_dinc = 0;
      m_tc = 0; m_err = 0; m_rdl = 0; m_wrl = 0; m_sa = '0; m_da = '0;
      q.delete();
    end else begin
      sv     = m_en && m_pend && (q.size() < 4);
      dv     = m_en && (q.size() > 0);
      gs     = sv && src_ready && !src_err;
      gd     = dv && dst_ready && !dst_err;
      bad    = (sv && src_ready && src_err) || (dv && dst_ready && dst_err);
      last   = gd && (m_wrl == 1);
      start  = cfg_we && cfg_enable && !m_en;
      stop   = cfg_we && !cfg_enable && m_en;
      accept = m_en && !m_halt && periph_req && !m_pend && (m_rdl != 0);
      kill   = bad || stop || last;
      pl     = prog_we && !m_en;
      if (gs) beats = beats;  // placeholder-free: beats counted at ports below
      if (gd) void'(q.pop_front());
      if (gs) q.push_back(src_data);
      if (kill) q.delete();
      if (clr_tc)  m_tc = 0;
      if (clr_err) m_err = 0;
      if (last || (start && !m_chain && m_wrl == 0)) m_tc = 1;
      if (bad || (start && m_chain)) m_err = 1;
      if (bad || stop) begin m_rdl = 0; m_wrl = 0; end
      else if (pl) begin m_rdl = prog_count; m_wrl = prog_count; end
      else begin
        if (gs) m_rdl--;
        if (gd) m_wrl--;
      end
      if (pl) begin m_sa = prog_src; m_da = prog_dst; end
      else begin
        if (gs && m_sinc) m_sa += 32'd4;
        if (gd && m_dinc) m_da += 32'd4;
      end
      if (kill || gs) m_pend = 0;
      else if (accept) m_pend = 1;
      if (kill) m_en = 0;
      else if (start && !m_chain && m_wrl_pre_nz(start)) m_en = 1;
      if (cfg_we) m_halt = cfg_halt;
      if (pl) begin
        m_chain = (prog_next != 0); m_sinc = prog_src_inc; m_dinc = prog_dst_inc;
      end
    end
  end

  // remaining count before this edge was non-zero whenever a start runs:
  // a start only happens while disabled, and the count is only cleared or
  // reloaded by events that are evaluated above; start_run needs the old value.
  int m_wrl_old;
  always @(negedge clk) m_wrl_old = m_wrl;
  function automatic bit m_wrl_pre_nz(input bit s);
    return s && (m_wrl_old != 0);
  endfunction

  // destination beats seen at the ports
  always @(posedge clk)
    if (rst_n && dst_valid && dst_ready && !dst_err) beats++;

  // ---------------- per-cycle comparison ----------------
  always @(negedge clk) begin
    if (rst_n && cyc > 4) begin
      chk(ch_enable === m_en, "R2", "ch_enable", 32'(ch_enable), 32'(m_en));
      chk(src_valid === (m_en && m_pend && q.size() < 4), "R3", "src_valid",
          32'(src_valid), 32'(m_en && m_pend && q.size() < 4));
      chk(dst_valid === (m_en && q.size() > 0), "R4", "dst_valid",
          32'(dst_valid), 32'(m_en && q.size() > 0));
      if (m_en && q.size() > 0)
        chk(dst_data === q[0], "R4", "dst_data", dst_data, q[0]);
      chk(src_addr === m_sa, "R5", "src_addr", src_addr, m_sa);
      chk(dst_addr === m_da, "R5", "dst_addr", dst_addr, m_da);
      chk(ch_active === (m_en && (m_pend || q.size() > 0)), "R7", "ch_active",
          32'(ch_active), 32'(m_en && (m_pend || q.size() > 0)));
      chk(irq_tc === m_tc, "R9", "irq_tc", 32'(irq_tc), 32'(m_tc));
      chk(irq_err === m_err, "R12", "irq_err", 32'(irq_err), 32'(m_err));
    end
  end

  // ---------------- bus and request driver ----------------
  always @(negedge clk) begin
    src_data   <= $urandom;
    src_err    <= inj_src;
    dst_err    <= inj_dst;
    periph_req <= req_rand ? 1'($urandom % 2) : req_want;
    case (rdy_mode)
      0:       begin src_ready <= 1'b1; dst_ready <= 1'b1; end
      1:       begin src_ready <= 1'b1; dst_ready <= 1'b0; end
      default: begin src_ready <= 1'($urandom % 2); dst_ready <= 1'($urandom % 3 != 0); end
    endcase
  end

  // ---------------- watchdog ----------------
  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      done = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog: actual %0d expected < %0d cycles", cyc, 100000);
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic prog(input logic [31:0] s, input logic [31:0] d, input logic [31:0] nx,
                      input int cnt, input bit si, input bit di);
    prog_src = s; prog_dst = d; prog_next = nx; prog_count = 12'(cnt);
    prog_src_inc = si; prog_dst_inc = di; prog_we = 1'b1;
    @(negedge clk);
    prog_we = 1'b0;
  endtask

  task automatic cfg(input bit e, input bit h);
    cfg_we = 1'b1; cfg_enable = e; cfg_halt = h;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic pulse_clr(input bit t, input bit e);
    clr_tc = t; clr_err = e;
    @(negedge clk);
    clr_tc = 1'b0; clr_err = 1'b0;
  endtask

  task automatic wait_flag(input bit want_err, input int lim, input string req);
    int n = 0;
    while (((want_err ? irq_err : irq_tc) !== 1'b1) && n < lim) begin
      @(negedge clk);
      n++;
    end
    chk(n < lim, req, "flag within limit", 32'(n), 32'(lim));
  endtask

  initial begin
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);

    // R1 reset state
    chk(!ch_enable && !ch_active && !src_valid && !dst_valid && !irq_tc && !irq_err,
        "R1", "reset outputs",
        {26'd0, ch_enable, ch_active, src_valid, dst_valid, irq_tc, irq_err}, 32'd0);

    // basic run, both increments
    req_want = 1; rdy_mode = 0; beats = 0;
    prog(32'h1000, 32'h2000, 32'h0, 6, 1, 1);
    cfg(1, 0);
    chk(ch_enable === 1'b1, "R2", "enable after cfg write", 32'(ch_enable), 32'd1);
    wait_flag(0, 200, "R9");
    chk(ch_enable === 1'b0, "R9", "self-disable", 32'(ch_enable), 32'd0);
    chk(beats == 6, "R4", "beats written", 32'(beats), 32'd6);
    chk(dst_addr == 32'h2018, "R5", "dst address after 6 words", dst_addr, 32'h2018);

    // R13 sticky across reprogramming, then clear
    prog(32'h1100, 32'h2100, 32'h0, 3, 1, 1);
    chk(irq_tc === 1'b1, "R13", "tc persists", 32'(irq_tc), 32'd1);
    pulse_clr(1, 0);
    chk(irq_tc === 1'b0, "R13", "tc cleared", 32'(irq_tc), 32'd0);

    // R10 zero count
    prog(32'h1200, 32'h2200, 32'h0, 0, 1, 1);
    cfg(1, 0);
    chk(irq_tc === 1'b1 && ch_enable === 1'b0 && !src_valid && !dst_valid, "R10",
        "zero count", {29'd0, irq_tc, ch_enable, src_valid | dst_valid}, 32'd4);
    pulse_clr(1, 0);

    // R13 set wins over clear in the same cycle
    cfg_we = 1'b1; cfg_enable = 1'b1; cfg_halt = 1'b0; clr_tc = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0; clr_tc = 1'b0;
    chk(irq_tc === 1'b1, "R13", "set beats clear", 32'(irq_tc), 32'd1);
    pulse_clr(1, 0);

    // R11 non-zero follow-on pointer
    prog(32'h1300, 32'h2300, 32'h40, 3, 1, 1);
    cfg(1, 0);
    chk(irq_err === 1'b1 && ch_enable === 1'b0, "R11", "chain refused",
        {30'd0, irq_err, ch_enable}, 32'd2);
    pulse_clr(0, 1);
    chk(irq_err === 1'b0, "R13", "err cleared", 32'(irq_err), 32'd0);

    // R6/R7 halt with a full FIFO and one accepted request
    rdy_mode = 1; beats = 0;
    prog(32'h4000, 32'h5000, 32'h0, 8, 1, 1);
    cfg(1, 0);
    repeat (12) @(negedge clk);
    chk(ch_active === 1'b1 && !dst_valid == 1'b0, "R7", "active with full FIFO",
        32'(ch_active), 32'd1);
    cfg(1, 1);
    rdy_mode = 0;
    repeat (20) @(negedge clk);
    chk(beats == 5, "R6", "pending request drained", 32'(beats), 32'd5);
    chk(ch_active === 1'b0 && ch_enable === 1'b1, "R7", "active falls, still enabled",
        {30'd0, ch_active, ch_enable}, 32'd1);
    chk(src_valid === 1'b0, "R6", "requests ignored while halted", 32'(src_valid), 32'd0);
    cfg(1, 0);
    wait_flag(0, 200, "R6");
    chk(beats == 8, "R6", "resume after halt", 32'(beats), 32'd8);
    pulse_clr(1, 0);

    // R8 abrupt disable drops data and count
    rdy_mode = 1; beats = 0;
    prog(32'h6000, 32'h7000, 32'h0, 10, 1, 1);
    cfg(1, 0);
    repeat (10) @(negedge clk);
    cfg(0, 0);
    chk(!ch_enable && !ch_active && !dst_valid && !src_valid, "R8", "disable drops",
        {28'd0, ch_enable, ch_active, dst_valid, src_valid}, 32'd0);
    rdy_mode = 0;
    repeat (3) @(negedge clk);
    chk(beats == 0, "R8", "no words written", 32'(beats), 32'd0);
    cfg(1, 0);
    chk(irq_tc === 1'b1 && ch_enable === 1'b0, "R8", "count discarded",
        {30'd0, irq_tc, ch_enable}, 32'd2);
    pulse_clr(1, 0);

    // R12 source error
    beats = 0; inj_src = 1;
    prog(32'h8000, 32'h9000, 32'h0, 5, 1, 1);
    cfg(1, 0);
    wait_flag(1, 50, "R12");
    inj_src = 0;
    chk(!ch_enable && !ch_active && beats == 0, "R12", "source error stops",
        {30'd0, ch_enable, ch_active}, 32'd0);
    pulse_clr(0, 1);

    // R12 destination error mid-transfer
    beats = 0;
    prog(32'h8100, 32'h9100, 32'h0, 6, 1, 1);
    cfg(1, 0);
    while (beats < 2) @(negedge clk);
    inj_dst = 1;
    wait_flag(1, 50, "R12");
    inj_dst = 0;
    chk(!ch_enable && !dst_valid, "R12", "destination error stops",
        {30'd0, ch_enable, dst_valid}, 32'd0);
    pulse_clr(0, 1);

    // R5 fixed addresses
    prog(32'h3000, 32'h3800, 32'h0, 4, 0, 0);
    cfg(1, 0);
    wait_flag(0, 200, "R9");
    chk(src_addr == 32'h3000 && dst_addr == 32'h3800, "R5", "no increment",
        src_addr, 32'h3000);
    pulse_clr(1, 0);

    // random readiness and requests; R2 prog ignored while enabled
    rdy_mode = 2; req_rand = 1;
    prog(32'hA000, 32'hB000, 32'h0, 20, 1, 1);
    cfg(1, 0);
    prog(32'hC000, 32'hD000, 32'h0, 2, 0, 0);
    wait_flag(0, 3000, "R3");
    chk(src_addr == 32'hA050, "R2", "prog ignored while enabled", src_addr, 32'hA050);
    req_rand = 0; rdy_mode = 0;
    pulse_clr(1, 0);

    repeat (4) @(negedge clk);
    if (!done) begin
      done = 1;
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end
endmodule